// File: doc/BRIEF.md
# Large-Page Linear-to-Physical Address Translator

The block turns a 32-bit linear address into a 36-bit physical address. It uses a single-level directory of 4 MiB pages. A consumer hands it a linear address on a valid/ready request port. The block then acts according to the enable bits of two control registers, sampled at that moment:

- If paging is off, it returns the address unchanged, zero-extended.
- If paging is on and the large-page mode is the legal one, it fetches one 32-bit directory entry through a memory-request port. It then builds the physical address from that entry, or reports a page fault.
- If paging is on under any other flag combination, it reports a configuration error.

The upper ten linear bits index a directory of 1024 entries. The low 22 bits are the byte offset inside the page and are never altered. The chosen entry supplies the 14 upper physical bits. As a result, up to 1024 pages can be placed anywhere in a 64 GiB physical space.

Only one translation is in flight at a time. A result is held on the response port until the consumer takes it, and only then does the block accept a new request.

Top module: `lpage_xlate`

## Requirements
- R1: After reset, `req_ready_o` is 1 and both `rsp_valid_o` and `mem_req_valid_o` are 0.
- R2: Paging is off when bit 31 of `cr0_i` is 0 at acceptance. In that case `rsp_valid_o` rises in the cycle after acceptance with `rsp_phys_o` = {4'b0, linear}, both flags clear, and no memory request.
- R3: Translation runs only when bit 31 of `cr0_i` is 1, bit 4 of `cr4_i` is 1 and bit 5 of `cr4_i` is 0. It then issues exactly one read, at address `dir_base_i` + linear[31:22] × 4.
- R4: An entry with bit 0 (present) = 1 and bit 7 (page size) = 1 yields `rsp_phys_o` = {entry[16:13], entry[31:22], linear[21:0]}, with both flags clear.
- R5: An entry with bit 0 = 0 or bit 7 = 0 yields `rsp_fault_o` = 1 and `rsp_phys_o` = 0.
- R6: Paging may be on (bit 31 of `cr0_i` = 1) with bits 4 and 5 of `cr4_i` not equal to 1 and 0. In that case the result appears in the cycle after acceptance with `rsp_cfg_err_o` = 1, `rsp_phys_o` = 0 and no memory request.
- R7: While `rsp_valid_o` is 1 and `rsp_ready_i` is 0, all response outputs stay unchanged.
- R8: `req_ready_o` is 0 from acceptance until the cycle after the result is taken. A request presented in the same cycle as the hand-off is not accepted in that cycle.
- R9: Control registers and the directory base are sampled at acceptance. Later changes have no effect on that translation.
- R10: `mem_req_valid_o` stays 1 with a stable `mem_req_addr_o` until `mem_req_ready_i` is seen.
- R11: `rsp_lin_o` returns the accepted linear address with every result, and `rsp_fault_o` and `rsp_cfg_err_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cr0_i | input | 32 | Control register 0 (bit 31 enables paging) |
| cr4_i | input | 32 | Control register 4 (bit 4 large pages, bit 5 extended entries) |
| dir_base_i | input | 32 | Byte address of the page directory |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_lin_i | input | 32 | Linear address to translate |
| mem_req_valid_o | output | 1 | Directory read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | 32 | Byte address of the directory entry |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Directory entry |
| rsp_valid_o | output | 1 | Result valid |
| rsp_ready_i | input | 1 | Consumer takes the result |
| rsp_phys_o | output | 36 | Physical address |
| rsp_fault_o | output | 1 | Page fault |
| rsp_cfg_err_o | output | 1 | Illegal control-flag combination |
| rsp_lin_o | output | 32 | Linear address of this result |

## Verification
Two events can fall in the same cycle: the consumer taking a pending result, and a new request arriving. The bench holds `req_valid_i` high during back-pressure and keeps it high through the hand-off edge. It then checks that the result is gone and that `req_ready_o` has only just returned, with no request swallowed. The control registers and directory base are re-randomised right after every acceptance. The bench then judges the result against values computed from the inputs captured at acceptance.

// File: rtl/lpage_xlate.sv
module lpage_xlate #(
  parameter int LIN_W    = 32,
  parameter int PHYS_W   = 36,
  parameter int OFF_W    = 22,
  parameter int CR_W     = 32,
  parameter int PG_BIT   = 31,
  parameter int LPG_BIT  = 4,
  parameter int EXT_BIT  = 5,
  parameter int PRES_BIT = 0,
  parameter int SIZE_BIT = 7,
  parameter int HI_LSB   = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CR_W-1:0]   cr0_i,
  input  logic [CR_W-1:0]   cr4_i,
  input  logic [LIN_W-1:0]  dir_base_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [LIN_W-1:0]  req_lin_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [LIN_W-1:0]  mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [LIN_W-1:0]  mem_rsp_data_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [PHYS_W-1:0] rsp_phys_o,
  output logic              rsp_fault_o,
  output logic              rsp_cfg_err_o,
  output logic [LIN_W-1:0]  rsp_lin_o
);

  localparam int IDX_W = LIN_W - OFF_W;
  localparam int HI_W  = PHYS_W - LIN_W;
  localparam int PAD_W = LIN_W - IDX_W - 2;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_DONE} st_t;

  st_t               st_q;
  logic [LIN_W-1:0]  lin_q, dir_q;
  logic [PHYS_W-1:0] phys_q;
  logic              fault_q, cfg_q;

  logic pg_on, mode_ok, ent_ok, accept;
  logic spare_unused;

  assign pg_on   = cr0_i[PG_BIT];
  assign mode_ok = cr4_i[LPG_BIT] & ~cr4_i[EXT_BIT];
  assign ent_ok  = mem_rsp_data_i[PRES_BIT] & mem_rsp_data_i[SIZE_BIT];
  assign accept  = req_valid_i & req_ready_o;
  assign spare_unused = ^{cr0_i, cr4_i, mem_rsp_data_i};

  assign req_ready_o     = (st_q == S_IDLE);
  assign mem_req_valid_o = (st_q == S_REQ);
  assign mem_req_addr_o  = dir_q + {{PAD_W{1'b0}}, lin_q[LIN_W-1 -: IDX_W], 2'b00};
  assign rsp_valid_o     = (st_q == S_DONE);
  assign rsp_phys_o      = phys_q;
  assign rsp_fault_o     = fault_q;
  assign rsp_cfg_err_o   = cfg_q;
  assign rsp_lin_o       = lin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      lin_q   <= '0;
      dir_q   <= '0;
      phys_q  <= '0;
      fault_q <= 1'b0;
      cfg_q   <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (accept) begin
          lin_q   <= req_lin_i;
          dir_q   <= dir_base_i;
          phys_q  <= '0;
          fault_q <= 1'b0;
          cfg_q   <= 1'b0;
          if (!pg_on) begin
            phys_q <= {{HI_W{1'b0}}, req_lin_i};
            st_q   <= S_DONE;
          end else if (mode_ok) begin
            st_q <= S_REQ;
          end else begin
            cfg_q <= 1'b1;
            st_q  <= S_DONE;
          end
        end
        S_REQ: if (mem_req_ready_i) st_q <= S_WAIT;
        S_WAIT: if (mem_rsp_valid_i) begin
          if (ent_ok)
            phys_q <= {mem_rsp_data_i[HI_LSB +: HI_W],
                       mem_rsp_data_i[LIN_W-1 -: IDX_W],
                       lin_q[OFF_W-1:0]};
          else
            fault_q <= 1'b1;
          st_q <= S_DONE;
        end
        S_DONE: if (rsp_ready_i) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lpage_xlate_chk.sv
module lpage_xlate_chk #(
  parameter int LIN_W   = 32,
  parameter int PHYS_W  = 36,
  parameter int CR_W    = 32,
  parameter int PG_BIT  = 31,
  parameter int LPG_BIT = 4,
  parameter int EXT_BIT = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CR_W-1:0]   cr0_i,
  input logic [CR_W-1:0]   cr4_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [LIN_W-1:0]  req_lin_i,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [LIN_W-1:0]  mem_req_addr_o,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [PHYS_W-1:0] rsp_phys_o,
  input logic              rsp_fault_o,
  input logic              rsp_cfg_err_o,
  input logic [LIN_W-1:0]  rsp_lin_o
);

  localparam int HI_W = PHYS_W - LIN_W;

  logic acc;
  assign acc = req_valid_i & req_ready_o;

  p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !cr0_i[PG_BIT] |=> rsp_valid_o && !mem_req_valid_o && !rsp_fault_o && !rsp_cfg_err_o
      && rsp_phys_o == {{HI_W{1'b0}}, $past(req_lin_i)});

  p_cfg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cr0_i[PG_BIT] && !(cr4_i[LPG_BIT] && !cr4_i[EXT_BIT])
      |=> rsp_valid_o && rsp_cfg_err_o && rsp_phys_o == '0 && !mem_req_valid_o);

  p_walk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cr0_i[PG_BIT] && cr4_i[LPG_BIT] && !cr4_i[EXT_BIT] |=> mem_req_valid_o);

  p_fault_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && rsp_fault_o |-> rsp_phys_o == '0);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_phys_o) && $stable(rsp_fault_o)
      && $stable(rsp_cfg_err_o) && $stable(rsp_lin_o));

  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o || mem_req_valid_o) |-> !req_ready_o);

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> !(rsp_fault_o && rsp_cfg_err_o));

endmodule

bind lpage_xlate lpage_xlate_chk #(
  .LIN_W(LIN_W), .PHYS_W(PHYS_W), .CR_W(CR_W),
  .PG_BIT(PG_BIT), .LPG_BIT(LPG_BIT), .EXT_BIT(EXT_BIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cr0_i(cr0_i), .cr4_i(cr4_i),
  .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_lin_i(req_lin_i),
  .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
  .mem_req_addr_o(mem_req_addr_o), .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i),
  .rsp_phys_o(rsp_phys_o), .rsp_fault_o(rsp_fault_o), .rsp_cfg_err_o(rsp_cfg_err_o),
  .rsp_lin_o(rsp_lin_o)
);

// File: tb/lpage_xlate_tb_top.sv
module lpage_xlate_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cr0 = '0, cr4 = '0, dir_base = '0, req_lin = '0, mem_data = '0;
  logic        req_valid = 1'b0, mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, rsp_ready = 1'b0;
  logic        req_ready, mem_req_valid, rsp_valid, rsp_fault, rsp_cfg_err;
  logic [31:0] mem_req_addr, rsp_lin;
  logic [35:0] rsp_phys;

  int nchk = 0;
  int nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpage_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .cr0_i(cr0), .cr4_i(cr4), .dir_base_i(dir_base),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_lin_i(req_lin),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_req_addr_o(mem_req_addr), .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rsp_data_i(mem_data), .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_phys_o(rsp_phys), .rsp_fault_o(rsp_fault), .rsp_cfg_err_o(rsp_cfg_err),
    .rsp_lin_o(rsp_lin)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // 0 = pass-through, 1 = directory walk, 2 = configuration error
  function automatic int mode_of(input logic [31:0] c0, input logic [31:0] c4);
    if (!c0[31]) return 0;
    if (c4[4] && !c4[5]) return 1;
    return 2;
  endfunction

  function automatic logic [35:0] exp_phys(input int m, input logic [31:0] lin, input logic [31:0] e);
    if (m == 0) return {4'b0, lin};
    if (m == 2) return '0;
    if (e[0] && e[7]) return {e[16:13], e[31:22], lin[21:0]};
    return '0;
  endfunction

  function automatic bit exp_fault(input int m, input logic [31:0] e);
    return (m == 1) && !(e[0] && e[7]);
  endfunction

  task automatic xact(input logic [31:0] lin, input logic [31:0] c0, input logic [31:0] c4,
                      input logic [31:0] base, input logic [31:0] ent);
    int m;
    int g;
    logic [35:0] ep;
    logic [35:0] held_p;
    m  = mode_of(c0, c4);
    ep = exp_phys(m, lin, ent);
    @(negedge clk);
    req_lin = lin; cr0 = c0; cr4 = c4; dir_base = base; req_valid = 1'b1;
    g = 0;
    while (!req_ready && g < 50) begin @(negedge clk); g++; end
    chk(req_ready, "R8 ready before accept", {63'b0, req_ready}, 64'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cr0 = $urandom; cr4 = $urandom; dir_base = $urandom;  // R9: late changes must be ignored
    if (m != 1) begin
      chk(rsp_valid && !mem_req_valid, m == 0 ? "R2 one-cycle bypass" : "R6 one-cycle cfg err",
          {62'b0, rsp_valid, mem_req_valid}, 64'd2);
    end else begin
      chk(mem_req_valid && !req_ready, "R8 busy during walk", {62'b0, mem_req_valid, req_ready}, 64'd2);
      chk(mem_req_addr == base + {20'b0, lin[31:22], 2'b00}, "R3 entry address",
          {32'b0, mem_req_addr}, {32'b0, base + {20'b0, lin[31:22], 2'b00}});
      repeat ($urandom_range(2)) begin
        @(negedge clk);
        chk(mem_req_valid && mem_req_addr == base + {20'b0, lin[31:22], 2'b00}, "R10 request held",
            {31'b0, mem_req_valid, mem_req_addr}, {31'b0, 1'b1, base + {20'b0, lin[31:22], 2'b00}});
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk(!mem_req_valid, "R3 single read", {63'b0, mem_req_valid}, 64'd0);
      repeat ($urandom_range(3)) begin
        @(negedge clk);
        chk(!rsp_valid && !mem_req_valid, "R3 no early result", {62'b0, rsp_valid, mem_req_valid}, 64'd0);
      end
      mem_data = ent; mem_rsp_valid = 1'b1;
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_data = $urandom;
      chk(rsp_valid, "R3 result after entry", {63'b0, rsp_valid}, 64'd1);
    end
    chk(rsp_phys == ep, m == 1 ? (exp_fault(m, ent) ? "R5 phys zero" : "R4 phys") : "R9 phys",
        {28'b0, rsp_phys}, {28'b0, ep});
    chk(rsp_fault == exp_fault(m, ent), "R5 fault flag", {63'b0, rsp_fault}, {63'b0, exp_fault(m, ent)});
    chk(rsp_cfg_err == (m == 2), "R6 cfg flag", {63'b0, rsp_cfg_err}, {63'b0, m == 2});
    chk(rsp_lin == lin && !(rsp_fault && rsp_cfg_err), "R11 lin echo", {32'b0, rsp_lin}, {32'b0, lin});
    held_p = rsp_phys;
    req_valid = 1'b1; req_lin = $urandom;
    repeat ($urandom_range(3)) begin
      @(negedge clk);
      chk(rsp_valid && rsp_phys == held_p && rsp_lin == lin, "R7 result held",
          {27'b0, rsp_valid, rsp_phys}, {27'b0, 1'b1, held_p});
      chk(!req_ready, "R8 no accept while pending", {63'b0, req_ready}, 64'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b0;
    chk(!rsp_valid && req_ready && !mem_req_valid, "R8 handoff not overlapping accept",
        {61'b0, rsp_valid, req_ready, mem_req_valid}, 64'd2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R8 watchdog act=hung exp=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 reset state",
        {61'b0, req_ready, rsp_valid, mem_req_valid}, 64'd4);

    xact(32'h0000_0000, 32'h0, 32'h10, 32'h1000, 32'h0);
    xact(32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h0, 32'h0, 32'h0);
    xact(32'h0000_1234, 32'h8000_0000, 32'h10, 32'h0001_0000, 32'h0000_0081);
    xact(32'hFFFF_FFFF, 32'h8000_0000, 32'h10, 32'hFFFF_F000, 32'hFFC1_E081);
    xact(32'h4040_0000, 32'h8000_0000, 32'h10, 32'h0002_0000, 32'hFFFF_FF80);
    xact(32'h4040_0000, 32'h8000_0000, 32'h10, 32'h0002_0000, 32'hFFFF_FF7F);
    xact(32'h1234_5678, 32'h8000_0000, 32'h00, 32'h0, 32'h0);
    xact(32'h1234_5678, 32'h8000_0000, 32'h30, 32'h0, 32'h0);
    xact(32'h1234_5678, 32'h8000_0000, 32'h20, 32'h0, 32'h0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] c0, c4, e;
      int k;
      k  = $urandom_range(9);
      c0 = $urandom; c4 = $urandom;
      c0[31] = (k != 0);
      if (k >= 3) begin c4[4] = 1'b1; c4[5] = 1'b0; end
      e = $urandom;
      if ($urandom_range(3) != 0) begin e[0] = 1'b1; e[7] = 1'b1; end
      xact($urandom, c0, c4, $urandom, e);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule